// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates the interrupt requests of an 8-bit microcontroller core. Nine sources feed it. Three of those sources are formed by merging two peripheral flags each. Every source is qualified by its own enable bit and by a global enable, and each source is placed at one of two priority levels. From the qualified requests the controller picks one to service. It then sends the CPU a one-cycle take strobe and a vector address. The vector stays on its output until the CPU acknowledges.

The controller keeps one in-service flag per level. A high-level request can nest on top of a low-level handler. A request at the level already in service must wait. A return-from-interrupt pulse releases the innermost active level.

Two enable bits live in a small byte-wide register that the core writes: one for the supply-monitor source and one for the I2C/SPI source. The seven remaining enables come in on pins.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset `irq_take` is 0, `irq_vector` is 0x0000, `in_service` is 2'b00 and `sec_rdata` is 0x00.
- R2: A write to the secondary enable register stores `sec_wdata[1]` as the supply-monitor enable (source 8) and `sec_wdata[0]` as the I2C/SPI enable (source 7). Bits 7..2 read back as 0 whatever is written. A source whose bit is 0 is never taken.
- R3: No interrupt is taken while `glb_en` is 0. Source k (k = 0..6) is never taken while `src_en[k]` is 0.
- R4: Among simultaneous requests at the same level, the winner is the first one in this order: source 8 (supply monitor), 0 (external 0), 6 (ADC), 1 (timer 0), 2 (external 1), 3 (timer 1), 7 (I2C/SPI), 4 (serial), 5 (timer 2).
- R5: Source k sits on `src_req[k]`, and its vector is 0x0003 + 8*k: ext0 0x03, timer0 0x0B, ext1 0x13, timer1 0x1B, serial 0x23, timer2 0x2B, ADC 0x33, I2C/SPI 0x3B, supply monitor 0x43.
- R6: When high-level (`prio_hi[k]`=1) and low-level requests are present together and nothing is in service, the high-level request is taken.
- R7: A take sets `in_service[1]` for a high-level take or `in_service[0]` for a low-level take. A high-level request is taken while only the low level is in service.
- R8: A request is never taken while its own level is in service. A low-level request is also never taken while the high level is in service.
- R9: A `reti` pulse clears `in_service[1]` if it is set, and otherwise clears `in_service[0]`. No take occurs in a cycle with `reti`.
- R10: `irq_take` lasts one cycle. `irq_vector` holds from that cycle until `cpu_ack` is seen in a later cycle. No new take occurs before that acknowledge.
- R11: Source 4 requests on `src_req[4]` OR `alt_req[0]`. Source 5 requests on `src_req[5]` OR `alt_req[1]`. Source 7 requests on `src_req[7]` OR `alt_req[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 9 | Primary request flag per source, indexed by vector number |
| alt_req | input | 3 | Second flags of the merged sources (serial, timer 2, I2C/SPI) |
| src_en | input | 7 | Enables for sources 0..6 |
| glb_en | input | 1 | Global interrupt enable |
| prio_hi | input | 9 | 1 = source at the high level |
| sec_we | input | 1 | Write strobe of the secondary enable register |
| sec_wdata | input | 8 | Write data of the secondary enable register |
| sec_rdata | output | 8 | Read value of the secondary enable register |
| cpu_ack | input | 1 | CPU acknowledges the presented vector |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_take | output | 1 | One-cycle strobe: take an interrupt |
| irq_vector | output | 16 | Vector address of the taken interrupt |
| in_service | output | 2 | In-service flags, bit 1 high level, bit 0 low level |

## Verification
Every ordered pair of the nine sources is requested together: first with both at the low level, then with one of the two raised to the high level. Equal-level pairs pin down the polling order and the vector of each source. The mixed-level pairs show that level decides before polling rank does. A scripted nesting sequence checks that nesting works across the two levels, that it is blocked within a level, and that a deferred low-level request is taken once the last `reti` arrives. Single-flag requests on the merged inputs, and patterns with enables or register bits cleared, separate gating faults from arbitration faults.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int NSRC  = 9;
    localparam int IDXW  = 4;
    localparam int VECW  = 16;
    localparam int NLVL  = 2;
    localparam int NPIN_EN = 7;

    typedef logic [NSRC-1:0] src_mask_t;
    typedef logic [IDXW-1:0] src_idx_t;

    typedef struct packed {
        logic            take;
        logic            take_hi;
        logic            pend;
        logic [NLVL-1:0] insvc;
        logic [VECW-1:0] vec;
    } ctl_state_t;

    // polling slot (0 = served first) to source number
    function automatic src_idx_t slot_src(input int slot);
        case (slot)
            0:       return 4'd8;
            1:       return 4'd0;
            2:       return 4'd6;
            3:       return 4'd1;
            4:       return 4'd2;
            5:       return 4'd3;
            6:       return 4'd7;
            7:       return 4'd4;
            default: return 4'd5;
        endcase
    endfunction

    // vectors are spaced by eight bytes starting at offset three
    function automatic logic [VECW-1:0] vec_of(input src_idx_t k);
        return {{(VECW-IDXW-3){1'b0}}, k, 3'b011};
    endfunction

endpackage

// File: rtl/nic_sec_en.sv
module nic_sec_en #(
    parameter int          DW      = 8,
    parameter logic [7:0]  WR_MASK = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          en_psm,
    output logic          en_i2c
);

    typedef struct packed {
        logic [DW-1:0] bits;
    } sec_state_t;

    sec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.bits = wdata & DW'(WR_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.bits;
    assign en_psm = st_q.bits[1];
    assign en_i2c = st_q.bits[0];

    // R2: a write shows up next cycle with the reserved bits forced to zero
    p_wr_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == {{(DW-2){1'b0}}, $past(wdata[1:0])}));

endmodule

// File: rtl/nic_req_gate.sv
module nic_req_gate
    import nic_pkg::*;
(
    input  src_mask_t            src_req,
    input  logic [2:0]           alt_req,
    input  logic [NPIN_EN-1:0]   src_en,
    input  logic                 en_i2c,
    input  logic                 en_psm,
    input  logic                 glb_en,
    input  src_mask_t            prio_hi,
    output src_mask_t            cand_hi,
    output src_mask_t            cand_lo
);

    src_mask_t merged;
    src_mask_t enables;
    src_mask_t qual;

    // sources built from two flags each: serial (4), timer 2 (5), I2C/SPI (7)
    always_comb begin
        merged    = src_req;
        merged[4] = src_req[4] | alt_req[0];
        merged[5] = src_req[5] | alt_req[1];
        merged[7] = src_req[7] | alt_req[2];
    end

    assign enables = {en_psm, en_i2c, src_en};
    assign qual    = merged & enables & {NSRC{glb_en}};
    assign cand_hi = qual & prio_hi;
    assign cand_lo = qual & ~prio_hi;

endmodule

// File: rtl/nic_level_pick.sv
module nic_level_pick
    import nic_pkg::*;
(
    input  src_mask_t cand,
    output logic      found,
    output src_idx_t  idx
);

    src_mask_t ordered;

    for (genvar s = 0; s < NSRC; s++) begin : g_slot
        assign ordered[s] = cand[slot_src(s)];
    end

    // scan downward so the earliest slot overwrites the later ones
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (ordered[s]) begin
                found = 1'b1;
                idx   = slot_src(s);
            end
        end
    end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [8:0]   src_req,
    input  logic [2:0]   alt_req,
    input  logic [6:0]   src_en,
    input  logic         glb_en,
    input  logic [8:0]   prio_hi,
    input  logic         sec_we,
    input  logic [7:0]   sec_wdata,
    output logic [7:0]   sec_rdata,
    input  logic         cpu_ack,
    input  logic         reti,
    output logic         irq_take,
    output logic [15:0]  irq_vector,
    output logic [1:0]   in_service
);

    localparam int LVL_LO = 0;
    localparam int LVL_HI = 1;

    logic      en_psm, en_i2c;
    src_mask_t cand [NLVL];
    logic      lvl_found [NLVL];
    src_idx_t  lvl_idx [NLVL];

    ctl_state_t s_d, s_q;

    nic_sec_en #(.DW(8), .WR_MASK(8'h03)) u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sec_we),
        .wdata  (sec_wdata),
        .rdata  (sec_rdata),
        .en_psm (en_psm),
        .en_i2c (en_i2c)
    );

    nic_req_gate u_gate (
        .src_req (src_req),
        .alt_req (alt_req),
        .src_en  (src_en),
        .en_i2c  (en_i2c),
        .en_psm  (en_psm),
        .glb_en  (glb_en),
        .prio_hi (prio_hi),
        .cand_hi (cand[LVL_HI]),
        .cand_lo (cand[LVL_LO])
    );

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        nic_level_pick u_pick (
            .cand  (cand[l]),
            .found (lvl_found[l]),
            .idx   (lvl_idx[l])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.take = 1'b0;

        // the acknowledge counts only after the strobe cycle
        if (s_q.pend && !s_q.take && cpu_ack) begin
            s_d.pend = 1'b0;
        end

        if (reti) begin
            if (s_q.insvc[LVL_HI]) begin
                s_d.insvc[LVL_HI] = 1'b0;
            end else begin
                s_d.insvc[LVL_LO] = 1'b0;
            end
        end else if (!s_q.pend) begin
            if (lvl_found[LVL_HI] && !s_q.insvc[LVL_HI]) begin
                s_d.take          = 1'b1;
                s_d.take_hi       = 1'b1;
                s_d.pend          = 1'b1;
                s_d.insvc[LVL_HI] = 1'b1;
                s_d.vec           = vec_of(lvl_idx[LVL_HI]);
            end else if (lvl_found[LVL_LO] && (s_q.insvc == '0)) begin
                s_d.take          = 1'b1;
                s_d.take_hi       = 1'b0;
                s_d.pend          = 1'b1;
                s_d.insvc[LVL_LO] = 1'b1;
                s_d.vec           = vec_of(lvl_idx[LVL_LO]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_take   = s_q.take;
    assign irq_vector = s_q.vec;
    assign in_service = s_q.insvc;

    // R10: strobe never lasts two cycles
    p_take_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_take);

    // R10: vector frozen while waiting for acknowledge
    p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && !s_q.take) |-> $stable(irq_vector));

    // R3: a take follows a cycle with the global enable set
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(glb_en));

    // R8: low-level take only from an idle state
    p_lo_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !s_q.take_hi) |-> ($past(s_q.insvc) == 2'b00));

    // R8: no high-level take on top of a high-level handler
    p_hi_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && s_q.take_hi) |-> !$past(s_q.insvc[LVL_HI]));

    // R7: the taken level is marked in service
    p_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> in_service[s_q.take_hi]);

    // R9: a return drops the high level first
    p_reti_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && s_q.insvc[LVL_HI]) |=> !s_q.insvc[LVL_HI]);

endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  src_req = '0;
    logic [2:0]  alt_req = '0;
    logic [6:0]  src_en = 7'h7F;
    logic        glb_en = 1'b1;
    logic [8:0]  prio_hi = '0;
    logic        sec_we = 1'b0;
    logic [7:0]  sec_wdata = '0;
    logic [7:0]  sec_rdata;
    logic        cpu_ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq_take;
    logic [15:0] irq_vector;
    logic [1:0]  in_service;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nest_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .alt_req(alt_req),
        .src_en(src_en), .glb_en(glb_en), .prio_hi(prio_hi),
        .sec_we(sec_we), .sec_wdata(sec_wdata), .sec_rdata(sec_rdata),
        .cpu_ack(cpu_ack), .reti(reti), .irq_take(irq_take),
        .irq_vector(irq_vector), .in_service(in_service)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R4 polling rank of source k (0 = first)
    function automatic int rank_of(input int k);
        case (k)
            8: return 0;
            0: return 1;
            6: return 2;
            1: return 3;
            2: return 4;
            3: return 5;
            7: return 6;
            4: return 7;
            default: return 8;
        endcase
    endfunction

    function automatic logic [15:0] vec_exp(input int k);
        return 16'(3 + 8 * k);
    endfunction

    task automatic sec_write(input logic [7:0] v);
        sec_we = 1'b1;
        sec_wdata = v;
        tick();
        sec_we = 1'b0;
    endtask

    // one request pattern, then full release through ack and reti
    task automatic shot(input logic [8:0] req, input logic [2:0] alt, input logic [8:0] prio,
                        input bit exp_take, input int exp_src, input bit exp_hi, input string tag);
        src_req = req;
        alt_req = alt;
        prio_hi = prio;
        tick();
        check({tag, " take"}, 32'(irq_take), 32'(exp_take));
        if (exp_take) begin
            check({tag, " vector"}, 32'(irq_vector), 32'(vec_exp(exp_src)));
            check({"R7 ", tag, " level"}, 32'(in_service), exp_hi ? 32'd2 : 32'd1);
        end
        src_req = '0;
        alt_req = '0;
        if (exp_take) begin
            tick();
            check("R10 strobe ends", 32'(irq_take), 32'd0);
            cpu_ack = 1'b1;
            tick();
            cpu_ack = 1'b0;
            reti = 1'b1;
            tick();
            reti = 1'b0;
            check("R9 released", 32'(in_service), 32'd0);
        end
        tick();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        // R1 reset state
        check("R1 take", 32'(irq_take), 32'd0);
        check("R1 vector", 32'(irq_vector), 32'd0);
        check("R1 in_service", 32'(in_service), 32'd0);
        check("R1 sec_rdata", 32'(sec_rdata), 32'd0);
        rst_n = 1'b1;
        tick();

        // R2 register masking
        sec_write(8'hFF);
        check("R2 readback", 32'(sec_rdata), 32'h03);
        sec_write(8'hFD);
        check("R2 readback2", 32'(sec_rdata), 32'h01);
        shot(9'h100, 3'b000, 9'h000, 1'b0, 8, 1'b0, "R2 psm off");
        sec_write(8'h02);
        shot(9'h080, 3'b000, 9'h000, 1'b0, 7, 1'b0, "R2 i2c off");
        sec_write(8'h03);

        // R4 R5 R6 pair sweep
        for (int i = 0; i < 9; i++) begin
            for (int j = 0; j < 9; j++) begin
                logic [8:0] rq;
                int w;
                rq = 9'(1 << i) | 9'(1 << j);
                w = (rank_of(i) <= rank_of(j)) ? i : j;
                shot(rq, 3'b000, 9'h000, 1'b1, w, 1'b0, "R4 R5 same level");
                if (i != j) begin
                    shot(rq, 3'b000, 9'(1 << i), 1'b1, i, 1'b1, "R6 high first");
                end
            end
        end

        // R11 merged sources
        shot(9'h000, 3'b001, 9'h000, 1'b1, 4, 1'b0, "R11 serial tx");
        shot(9'h000, 3'b010, 9'h000, 1'b1, 5, 1'b0, "R11 timer2 ext");
        shot(9'h000, 3'b100, 9'h080, 1'b1, 7, 1'b1, "R11 spi");

        // R3 gating
        glb_en = 1'b0;
        shot(9'h1FF, 3'b111, 9'h1FF, 1'b0, 0, 1'b0, "R3 global off");
        glb_en = 1'b1;
        src_en = 7'h7E;
        shot(9'h001, 3'b000, 9'h000, 1'b0, 0, 1'b0, "R3 ext0 off");
        shot(9'h003, 3'b000, 9'h000, 1'b1, 1, 1'b0, "R3 next source");
        src_en = 7'h7F;

        // R10 hold until acknowledge
        src_req = 9'h008;
        prio_hi = 9'h000;
        tick();
        check("R10 take", 32'(irq_take), 32'd1);
        for (int c = 0; c < 3; c++) begin
            tick();
            check("R10 single strobe", 32'(irq_take), 32'd0);
            check("R10 vector held", 32'(irq_vector), 32'h1B);
        end
        src_req = '0;
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        reti = 1'b1;
        tick();
        reti = 1'b0;
        tick();

        // R7 R8 R9 nesting
        prio_hi = 9'h00C;
        src_req = 9'h001;
        tick();
        check("R7 low take", 32'(irq_vector), 32'h03);
        check("R7 low level", 32'(in_service), 32'd1);
        src_req = '0;
        tick();
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        src_req = 9'h002;
        tick();
        check("R8 low blocked", 32'(irq_take), 32'd0);
        src_req = 9'h00A;
        tick();
        check("R7 nest take", 32'(irq_take), 32'd1);
        check("R7 nest vector", 32'(irq_vector), 32'h1B);
        check("R7 both levels", 32'(in_service), 32'd3);
        src_req = 9'h002;
        tick();
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        src_req = 9'h006;
        tick();
        check("R8 high blocked", 32'(irq_take), 32'd0);
        src_req = 9'h002;
        reti = 1'b1;
        tick();
        reti = 1'b0;
        check("R9 high cleared", 32'(in_service), 32'd1);
        check("R8 still blocked", 32'(irq_take), 32'd0);
        tick();
        check("R8 low waits", 32'(irq_take), 32'd0);
        reti = 1'b1;
        tick();
        reti = 1'b0;
        check("R9 low cleared", 32'(in_service), 32'd0);
        check("R9 no take with reti", 32'(irq_take), 32'd0);
        tick();
        check("R8 deferred take", 32'(irq_take), 32'd1);
        check("R8 deferred vector", 32'(irq_vector), 32'h0B);
        src_req = '0;
        tick();
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        reti = 1'b1;
        tick();
        reti = 1'b0;
        check("R9 final", 32'(in_service), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule